// File: doc/BRIEF.md
# Stride Reference Prediction Prefetcher

This block watches the stream of load addresses issued by memory instructions and predicts the next address each instruction will touch. It keeps one table entry per instruction address. Each entry stores the address that instruction last referenced, the distance between its last two references and a two-bit confidence state. The table is direct-mapped on the low bits of the instruction address, and the remaining upper bits are kept as a tag.

On every access the block compares the new address with the prediction, which is the previous address plus the stored stride. It then moves the entry through a four-state confidence machine and, unless the entry ends up in the no-prediction state, forms a prefetch candidate equal to the current address plus the stride. Before a candidate leaves the block it is filtered. It is dropped if the first-level cache tag probe reports the line present, if the line is already in flight, if the in-flight list is full, or if the single output request register is stalled.

Accepted requests are held on a valid/ready handshake. When the handshake completes, the line enters a small in-flight list, and a fill-complete input with a matching line address removes it from that list again.

Top module: `stride_ref_prefetch`

## Requirements
- R1: After reset, pf_valid and l1_probe_valid are low and every table entry is empty, so the first access from any instruction address is treated as new.
- R2: An access whose index entry is empty or holds a different tag allocates the entry in the init state with a stride of zero, and its candidate is the line of the access address itself.
- R3: From init, a correct prediction moves the entry to steady and keeps the stride. An incorrect one moves it to transient and sets the stride to the new address minus the previous address.
- R4: From steady, a correct prediction stays in steady. An incorrect one returns to init and leaves the stride unchanged.
- R5: From transient, a correct prediction moves the entry to steady. An incorrect one moves it to no-prediction and updates the stride.
- R6: An access that leaves its entry in no-prediction produces no candidate. From no-prediction, a correct prediction moves the entry to transient, and an incorrect one stays in no-prediction and updates the stride.
- R7: A candidate's line address is bits [ADDR_W-1:6] of the access address plus the stride after update. If an access is sampled at rising edge n, its surviving request shows on pf_valid/pf_line after edge n+1.
- R8: In the cycle after the access, l1_probe_valid/l1_probe_line present the candidate line. A high l1_hit in that cycle discards the candidate.
- R9: A candidate whose line equals an entry of the in-flight list, or equals the line of the request currently held on the output, is discarded.
- R10: The in-flight list holds 4 lines. A line is added when pf_valid and pf_ready are both high. The line is removed when fill_valid arrives with the same line address. A candidate is discarded while list entries plus a held request reach 4.
- R11: While pf_valid is high and pf_ready is low, pf_line holds steady and any new candidate is discarded.
- R12: The table index is acc_pc[8:0] (512 entries) and the tag is acc_pc[31:9]. Two addresses with the same index and different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A load access is presented this cycle |
| acc_pc | input | 32 | Instruction address of the load |
| acc_addr | input | 32 | Byte address referenced by the load |
| l1_probe_valid | output | 1 | Candidate line is being probed in the cache tags |
| l1_probe_line | output | 26 | Line address being probed |
| l1_hit | input | 1 | Probed line is present in the cache (same cycle) |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Memory side accepts the request |
| pf_line | output | 26 | Line address to prefetch |
| fill_valid | input | 1 | A prefetch fill has completed |
| fill_line | input | 26 | Line address of the completed fill |

## Verification
The properties assume that l1_hit is a combinational answer to the line shown on the probe port in the same cycle. They also assume that fill_valid only names lines that were earlier handed out on pf_line and have not yet been filled, or lines that are in flight nowhere, which the block then ignores. The stimulus answers the probe through a fixed rule on the line number. Its fills either pick a line from the bench's own record of accepted requests or draw a random line. It never presents a fill for a line in the same cycle that line is being handed over. Access streams come from a handful of instruction addresses with small strides, one of them aliasing another's table index, with occasional jumps and stride changes so that every confidence transition is reached.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_TRANS  = 2'd1,
    ST_STEADY = 2'd2,
    ST_NOPRED = 2'd3
  } conf_state_e;

endpackage

// File: rtl/rpt_table.sv
module rpt_table
  import rpt_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int ADDR_W   = 32,
  parameter int ENTRIES  = 512,
  parameter int LINE_OFF = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  input  logic [PC_W-1:0]            acc_pc,
  input  logic [ADDR_W-1:0]          acc_addr,
  output logic                       cand_valid,
  output logic [ADDR_W-LINE_OFF-1:0] cand_line
);

  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int TAG_W  = PC_W - IDX_W;
  localparam int LINE_W = ADDR_W - LINE_OFF;

  // entry payload: no reset, validity is tracked separately
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [ADDR_W-1:0]  prev_q   [ENTRIES];
  logic [ADDR_W-1:0]  stride_q [ENTRIES];
  conf_state_e        state_q  [ENTRIES];
  logic [ENTRIES-1:0] used_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_prev;
  logic [ADDR_W-1:0] rd_stride;
  conf_state_e       rd_state;
  logic              rd_hit;
  logic [ADDR_W-1:0] rd_pred;
  logic [ADDR_W-1:0] delta;
  logic              correct;

  conf_state_e       nxt_state;
  logic [ADDR_W-1:0] nxt_stride;
  logic              do_issue;
  logic [ADDR_W-1:0] issue_addr;

  logic              cand_valid_q;
  logic [LINE_W-1:0] cand_line_q;

  assign idx       = acc_pc[IDX_W-1:0];
  assign tag       = acc_pc[PC_W-1:IDX_W];
  assign rd_tag    = tag_q[idx];
  assign rd_prev   = prev_q[idx];
  assign rd_stride = stride_q[idx];
  assign rd_state  = state_q[idx];
  assign rd_hit    = used_q[idx] && (rd_tag == tag);
  assign rd_pred   = rd_prev + rd_stride;
  assign delta     = acc_addr - rd_prev;
  assign correct   = (acc_addr == rd_pred);

  // confidence machine: next state and stride
  always_comb begin
    nxt_state  = ST_INIT;
    nxt_stride = '0;
    if (rd_hit) begin
      nxt_stride = rd_stride;
      unique case (rd_state)
        ST_INIT: begin
          if (correct) begin
            nxt_state = ST_STEADY;
          end else begin
            nxt_state  = ST_TRANS;
            nxt_stride = delta;
          end
        end
        ST_STEADY: begin
          nxt_state = correct ? ST_STEADY : ST_INIT;
        end
        ST_TRANS: begin
          if (correct) begin
            nxt_state = ST_STEADY;
          end else begin
            nxt_state  = ST_NOPRED;
            nxt_stride = delta;
          end
        end
        ST_NOPRED: begin
          if (correct) begin
            nxt_state = ST_TRANS;
          end else begin
            nxt_state  = ST_NOPRED;
            nxt_stride = delta;
          end
        end
      endcase
    end
  end

  assign do_issue   = acc_valid && (nxt_state != ST_NOPRED);
  assign issue_addr = acc_addr + nxt_stride;

  // entry payload write
  always_ff @(posedge clk) begin
    if (acc_valid) begin
      tag_q[idx]    <= tag;
      prev_q[idx]   <= acc_addr;
      stride_q[idx] <= nxt_stride;
      state_q[idx]  <= nxt_state;
    end
  end

  // entry validity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (acc_valid) begin
      used_q[idx] <= 1'b1;
    end
  end

  // candidate stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_valid_q <= 1'b0;
      cand_line_q  <= '0;
    end else begin
      cand_valid_q <= do_issue;
      if (do_issue) begin
        cand_line_q <= issue_addr[ADDR_W-1:LINE_OFF];
      end
    end
  end

  assign cand_valid = cand_valid_q;
  assign cand_line  = cand_line_q;

endmodule

// File: rtl/rpt_req_list.sv
module rpt_req_list #(
  parameter int LINE_W = 26,
  parameter int DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ins_valid,
  input  logic [LINE_W-1:0]            ins_line,
  input  logic                         fill_valid,
  input  logic [LINE_W-1:0]            fill_line,
  input  logic [LINE_W-1:0]            cmp_line,
  output logic                         cmp_match,
  output logic [$clog2(DEPTH+1)-1:0]   occupancy
);

  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DEPTH-1:0]  slot_v_q;
  logic [LINE_W-1:0] slot_line_q [DEPTH];
  logic [DEPTH-1:0]  hit_vec;
  logic [DEPTH-1:0]  clr_vec;
  logic [DEPTH-1:0]  ins_sel;
  logic              found;

  // lowest free slot takes the new line
  always_comb begin
    ins_sel = '0;
    found   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!slot_v_q[i] && !found) begin
        ins_sel[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign hit_vec[g] = slot_v_q[g] && (slot_line_q[g] == cmp_line);
    assign clr_vec[g] = fill_valid && slot_v_q[g] && (slot_line_q[g] == fill_line);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_v_q[g] <= 1'b0;
      end else if (ins_valid && ins_sel[g]) begin
        slot_v_q[g] <= 1'b1;
      end else if (clr_vec[g]) begin
        slot_v_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (ins_valid && ins_sel[g]) begin
        slot_line_q[g] <= ins_line;
      end
    end
  end

  assign cmp_match = |hit_vec;

  always_comb begin
    occupancy = '0;
    for (int i = 0; i < DEPTH; i++) begin
      occupancy = occupancy + CNT_W'(slot_v_q[i]);
    end
  end

endmodule

// File: rtl/rpt_issue.sv
module rpt_issue #(
  parameter int LINE_W = 26,
  parameter int DEPTH  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cand_valid,
  input  logic [LINE_W-1:0]          cand_line,
  input  logic                       l1_hit,
  input  logic                       orl_match,
  input  logic [$clog2(DEPTH+1)-1:0] orl_occ,
  input  logic                       pf_ready,
  output logic                       pf_valid,
  output logic [LINE_W-1:0]          pf_line,
  output logic                       push_valid,
  output logic [LINE_W-1:0]          push_line
);

  localparam int CNT_W = $clog2(DEPTH+1);

  logic              pf_valid_q;
  logic [LINE_W-1:0] pf_line_q;
  logic              stall;
  logic              fire;
  logic              held_match;
  logic [CNT_W:0]    inflight;
  logic              room;
  logic              load;
  logic              pf_valid_d;

  assign stall      = pf_valid_q && !pf_ready;
  assign fire       = pf_valid_q && pf_ready;
  assign held_match = pf_valid_q && (pf_line_q == cand_line);
  assign inflight   = {1'b0, orl_occ} + (CNT_W+1)'(pf_valid_q);
  assign room       = inflight < (CNT_W+1)'(DEPTH);
  assign load       = cand_valid && !l1_hit && !orl_match && !held_match && room && !stall;
  assign pf_valid_d = load || stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid_q <= 1'b0;
      pf_line_q  <= '0;
    end else begin
      pf_valid_q <= pf_valid_d;
      if (load) begin
        pf_line_q <= cand_line;
      end
    end
  end

  assign pf_valid   = pf_valid_q;
  assign pf_line    = pf_line_q;
  assign push_valid = fire;
  assign push_line  = pf_line_q;

endmodule

// File: rtl/stride_ref_prefetch.sv
module stride_ref_prefetch #(
  parameter int  PC_W      = 32,
  parameter int  ADDR_W    = 32,
  parameter int  ENTRIES   = 512,
  parameter int  LINE_OFF  = 6,
  parameter int  ORL_DEPTH = 4,
  localparam int LINE_W    = ADDR_W - LINE_OFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              l1_probe_valid,
  output logic [LINE_W-1:0] l1_probe_line,
  input  logic              l1_hit,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [LINE_W-1:0] pf_line,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line
);

  localparam int CNT_W = $clog2(ORL_DEPTH+1);

  logic              cand_valid;
  logic [LINE_W-1:0] cand_line;
  logic              orl_match;
  logic [CNT_W-1:0]  orl_occ;
  logic              push_valid;
  logic [LINE_W-1:0] push_line;

  rpt_table #(
    .PC_W    (PC_W),
    .ADDR_W  (ADDR_W),
    .ENTRIES (ENTRIES),
    .LINE_OFF(LINE_OFF)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_pc    (acc_pc),
    .acc_addr  (acc_addr),
    .cand_valid(cand_valid),
    .cand_line (cand_line)
  );

  rpt_req_list #(
    .LINE_W(LINE_W),
    .DEPTH (ORL_DEPTH)
  ) u_orl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (push_valid),
    .ins_line  (push_line),
    .fill_valid(fill_valid),
    .fill_line (fill_line),
    .cmp_line  (cand_line),
    .cmp_match (orl_match),
    .occupancy (orl_occ)
  );

  rpt_issue #(
    .LINE_W(LINE_W),
    .DEPTH (ORL_DEPTH)
  ) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand_valid(cand_valid),
    .cand_line (cand_line),
    .l1_hit    (l1_hit),
    .orl_match (orl_match),
    .orl_occ   (orl_occ),
    .pf_ready  (pf_ready),
    .pf_valid  (pf_valid),
    .pf_line   (pf_line),
    .push_valid(push_valid),
    .push_line (push_line)
  );

  assign l1_probe_valid = cand_valid;
  assign l1_probe_line  = cand_line;

endmodule

// File: rtl/stride_ref_prefetch_chk.sv
module stride_ref_prefetch_chk
  import rpt_pkg::*;
#(
  parameter int  ADDR_W   = 32,
  parameter int  LINE_OFF = 6,
  parameter int  DEPTH    = 4,
  localparam int LINE_W   = ADDR_W - LINE_OFF,
  localparam int CNT_W    = $clog2(DEPTH+1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [LINE_W-1:0] pf_line,
  input logic              l1_hit,
  input logic              cand_valid,
  input logic              rd_hit,
  input conf_state_e       rd_state,
  input logic [ADDR_W-1:0] rd_prev,
  input logic [ADDR_W-1:0] rd_stride,
  input logic [CNT_W-1:0]  orl_occ
);

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_line)); // R11

  AST_INFLIGHT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(orl_occ) + 32'(pf_valid)) <= DEPTH); // R10

  AST_L1_PRESENT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && l1_hit && !pf_valid |=> !pf_valid); // R8

  AST_NOPRED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && rd_hit && (rd_state == ST_NOPRED) && (acc_addr != rd_prev + rd_stride)
    |=> !cand_valid); // R6

  AST_NEW_ENTRY_PREDICTS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !rd_hit |=> cand_valid); // R2

  AST_REQ_FROM_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> $past(cand_valid)); // R7

endmodule

bind stride_ref_prefetch stride_ref_prefetch_chk #(
  .ADDR_W  (ADDR_W),
  .LINE_OFF(LINE_OFF),
  .DEPTH   (ORL_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_addr  (acc_addr),
  .pf_valid  (pf_valid),
  .pf_ready  (pf_ready),
  .pf_line   (pf_line),
  .l1_hit    (l1_hit),
  .cand_valid(cand_valid),
  .rd_hit    (u_table.rd_hit),
  .rd_state  (u_table.rd_state),
  .rd_prev   (u_table.rd_prev),
  .rd_stride (u_table.rd_stride),
  .orl_occ   (orl_occ)
);

// File: tb/stride_ref_prefetch_test.sv
`timescale 1ns/1ps
module stride_ref_prefetch_test;

  localparam int ENT   = 512;
  localparam int DEP   = 4;
  localparam int LW    = 26;

  logic          clk;
  logic          rst_n;
  logic          acc_valid;
  logic [31:0]   acc_pc;
  logic [31:0]   acc_addr;
  logic          l1_probe_valid;
  logic [LW-1:0] l1_probe_line;
  logic          l1_hit;
  logic          pf_valid;
  logic          pf_ready;
  logic [LW-1:0] pf_line;
  logic          fill_valid;
  logic [LW-1:0] fill_line;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  bit    l1_en  = 0;
  bit    rdy_dir = 1;
  int    fmode_dir = 1;
  string cur_tag = "R7";

  // bench reference state
  bit          m_ev  [ENT];
  logic [22:0] m_tag [ENT];
  logic [31:0] m_prev[ENT];
  logic [31:0] m_str [ENT];
  int          m_st  [ENT];   // 0 init, 1 transient, 2 steady, 3 no-pred
  bit          m_candv;
  logic [LW-1:0] m_cand;
  bit          m_pfv;
  logic [LW-1:0] m_pfl;
  bit          o_v [DEP];
  logic [LW-1:0] o_l [DEP];

  stride_ref_prefetch uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_pc(acc_pc), .acc_addr(acc_addr),
    .l1_probe_valid(l1_probe_valid), .l1_probe_line(l1_probe_line), .l1_hit(l1_hit),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line),
    .fill_valid(fill_valid), .fill_line(fill_line)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit l1_present(input logic [LW-1:0] ln);
    return (ln % 26'd5) == 26'd0;
  endfunction

  assign l1_hit = l1_en && l1_present(l1_probe_line);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < ENT; i++) m_ev[i] = 0;
    for (int j = 0; j < DEP; j++) o_v[j] = 0;
    m_candv = 0; m_cand = '0; m_pfv = 0; m_pfl = '0;
  endtask

  task automatic compare();
    chk(pf_valid === m_pfv, cur_tag, "pf_valid", 64'(pf_valid), 64'(m_pfv));
    if (m_pfv) chk(pf_line === m_pfl, cur_tag, "pf_line", 64'(pf_line), 64'(m_pfl));
    chk(l1_probe_valid === m_candv, "R8", "l1_probe_valid", 64'(l1_probe_valid), 64'(m_candv));
    if (m_candv) chk(l1_probe_line === m_cand, "R8", "l1_probe_line", 64'(l1_probe_line), 64'(m_cand));
  endtask

  // one clock of the reference behaviour, computed from the requirements
  task automatic cycle(input bit av, input logic [31:0] pc, input logic [31:0] ad,
                       input int fmode, input logic [LW-1:0] fl_in);
    bit fv; logic [LW-1:0] fl;
    bit stall, fire, held, match, hit, load; int occ; int fj;
    bit n_candv; logic [LW-1:0] n_cand; bit n_pfv; logic [LW-1:0] n_pfl;
    bit nv [DEP]; logic [LW-1:0] nl [DEP];
    compare();
    fv = 0; fl = '0;
    if (fmode == 1) begin
      for (int j = 0; j < DEP; j++) if (o_v[j] && !fv) begin fv = 1; fl = o_l[j]; end
    end else if (fmode == 2) begin
      int j = int'($urandom % DEP);
      if ($urandom % 3 == 0) begin fv = 1; fl = o_v[j] ? o_l[j] : LW'($urandom); end
    end else if (fmode == 3) begin
      fv = 1; fl = fl_in;
    end
    acc_valid = av; acc_pc = pc; acc_addr = ad; pf_ready = rdy_dir;
    fill_valid = fv; fill_line = fl;
    // output stage and in-flight list
    stall = m_pfv && !rdy_dir;
    fire  = m_pfv && rdy_dir;
    held  = m_pfv && (m_pfl == m_cand);
    match = 0; occ = 0;
    for (int j = 0; j < DEP; j++) begin
      if (o_v[j] && o_l[j] == m_cand) match = 1;
      if (o_v[j]) occ++;
    end
    hit  = l1_en && l1_present(m_cand);
    load = m_candv && !hit && !match && !held && (occ + int'(m_pfv) < DEP) && !stall;
    n_pfv = load || stall;
    n_pfl = load ? m_cand : m_pfl;
    fj = -1;
    for (int j = 0; j < DEP; j++) if (!o_v[j] && fj < 0) fj = j;
    for (int j = 0; j < DEP; j++) begin
      nv[j] = o_v[j] && !(fv && o_l[j] == fl);
      nl[j] = o_l[j];
    end
    if (fire && fj >= 0) begin nv[fj] = 1; nl[fj] = m_pfl; end
    // table
    n_candv = 0; n_cand = m_cand;
    if (av) begin
      int idx = int'(pc[8:0]);
      bit eh = m_ev[idx] && (m_tag[idx] == pc[31:9]);
      int ns; logic [31:0] nstr;
      if (!eh) begin
        ns = 0; nstr = 32'd0;
      end else begin
        bit ok = (ad == m_prev[idx] + m_str[idx]);
        logic [31:0] d = ad - m_prev[idx];
        nstr = m_str[idx];
        case (m_st[idx])
          0: if (ok) ns = 2; else begin ns = 1; nstr = d; end
          2: ns = ok ? 2 : 0;
          1: if (ok) ns = 2; else begin ns = 3; nstr = d; end
          default: if (ok) ns = 1; else begin ns = 3; nstr = d; end
        endcase
      end
      m_ev[idx] = 1; m_tag[idx] = pc[31:9]; m_prev[idx] = ad; m_str[idx] = nstr; m_st[idx] = ns;
      if (ns != 3) begin
        logic [31:0] pa = ad + nstr;
        n_candv = 1; n_cand = pa[31:6];
      end
    end
    @(posedge clk);
    m_candv = n_candv; m_cand = n_cand; m_pfv = n_pfv; m_pfl = n_pfl;
    for (int j = 0; j < DEP; j++) begin o_v[j] = nv[j]; o_l[j] = nl[j]; end
    @(negedge clk);
  endtask

  task automatic acc(input logic [31:0] pc, input logic [31:0] ad);
    cycle(1, pc, ad, fmode_dir, '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, 32'd0, 32'd0, fmode_dir, '0);
  endtask

  task automatic fill(input logic [LW-1:0] ln);
    cycle(0, 32'd0, 32'd0, 3, ln);
  endtask

  task automatic expect_pf(input bit v, input logic [LW-1:0] ln, input string tag);
    chk(pf_valid === v, tag, "pf_valid directed", 64'(pf_valid), 64'(v));
    if (v) chk(pf_line === ln, tag, "pf_line directed", 64'(pf_line), 64'(ln));
  endtask

  // access then observe the request one edge later
  task automatic acc_expect(input logic [31:0] pc, input logic [31:0] ad,
                            input bit v, input logic [LW-1:0] ln, input string tag);
    cur_tag = tag;
    acc(pc, ad);
    idle(1);
    expect_pf(v, ln, tag);
    idle(2);
  endtask

  initial begin
    logic [31:0] s_pc [6];
    logic [31:0] s_ad [6];
    logic [31:0] s_st [6];
    void'($urandom(32'd20240611));
    rst_n = 0; acc_valid = 0; acc_pc = '0; acc_addr = '0; pf_ready = 0;
    fill_valid = 0; fill_line = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: idle after reset
    chk(pf_valid === 1'b0, "R1", "pf_valid after reset", 64'(pf_valid), 64'd0);
    chk(l1_probe_valid === 1'b0, "R1", "probe after reset", 64'(l1_probe_valid), 64'd0);

    // R2/R7: first access allocates with stride zero
    rdy_dir = 1; fmode_dir = 1; l1_en = 0;
    acc_expect(32'h100, 32'h1000, 1, 26'h40, "R2");
    // R3: init -> transient (stride 0x100), then transient -> steady
    acc_expect(32'h100, 32'h1100, 1, 26'h48, "R3");
    acc_expect(32'h100, 32'h1200, 1, 26'h4C, "R3");
    // R4: steady stays, then miss returns to init keeping the stride
    acc_expect(32'h100, 32'h1300, 1, 26'h50, "R4");
    acc_expect(32'h100, 32'h5000, 1, 26'h144, "R4");
    acc_expect(32'h100, 32'h5100, 1, 26'h148, "R7");
    // R5/R6: walk through transient and no-prediction
    acc_expect(32'h100, 32'h9000, 1, 26'h244, "R4");
    acc_expect(32'h100, 32'h9040, 1, 26'h242, "R3");
    acc_expect(32'h100, 32'h9100, 0, 26'h0,   "R5");
    acc_expect(32'h100, 32'h9200, 0, 26'h0,   "R6");
    acc_expect(32'h100, 32'h9300, 1, 26'h250, "R6");
    acc_expect(32'h100, 32'h9400, 1, 26'h254, "R5");

    // R12: an aliasing address evicts, old address restarts from stride zero
    acc_expect(32'h300, 32'hA000, 1, 26'h280, "R12");
    acc_expect(32'h100, 32'h20000, 1, 26'h800, "R12");
    acc_expect(32'h100, 32'h20040, 1, 26'h802, "R12");

    // R8: line reported present by the cache probe is dropped
    l1_en = 1; cur_tag = "R8";
    acc(32'h104, 32'h1400);
    chk(l1_probe_valid === 1'b1, "R8", "probe valid", 64'(l1_probe_valid), 64'd1);
    chk(l1_probe_line === 26'h50, "R8", "probe line", 64'(l1_probe_line), 64'h50);
    idle(1);
    expect_pf(0, 26'h0, "R8");
    idle(2);
    acc_expect(32'h104, 32'h1440, 1, 26'h52, "R8");
    l1_en = 0;

    // R11: stalled request holds, newer candidate is lost
    rdy_dir = 0;
    acc_expect(32'h108, 32'h3000, 1, 26'hC0, "R11");
    acc(32'h10C, 32'h7000);
    idle(3);
    expect_pf(1, 26'hC0, "R11");
    rdy_dir = 1;
    idle(1);
    expect_pf(0, 26'h0, "R11");
    idle(3);
    expect_pf(0, 26'h0, "R11");

    // R9/R10: in-flight list capacity, matching and release by fill
    fmode_dir = 0;
    acc_expect(32'h110, 32'hB000, 1, 26'h2C0, "R10");
    acc_expect(32'h114, 32'hB100, 1, 26'h2C4, "R10");
    acc_expect(32'h118, 32'hB200, 1, 26'h2C8, "R10");
    acc_expect(32'h11C, 32'hB300, 1, 26'h2CC, "R10");
    acc_expect(32'h120, 32'hC000, 0, 26'h0,   "R10");
    fill(26'h2C0);
    acc_expect(32'h124, 32'hB100, 0, 26'h0,   "R9");
    acc_expect(32'h128, 32'hC000, 1, 26'h300, "R10");
    fill(26'h2C4); fill(26'h2C8); fill(26'h2CC); fill(26'h300);
    idle(2);

    // constrained random phase
    for (int k = 0; k < 6; k++) begin
      s_pc[k] = 32'h0000_4000 + 32'(k * 8);
      s_ad[k] = 32'h0010_0000 * 32'(k + 1);
      s_st[k] = 32'(k * 64 - 128);
    end
    s_pc[5] = s_pc[0] + 32'(ENT);
    l1_en = 1; cur_tag = "R7";
    for (int c = 0; c < 4000; c++) begin
      int k = int'($urandom % 6);
      bit av = ($urandom % 10) < 7;
      rdy_dir = ($urandom % 4) != 0;
      if (av) begin
        if ($urandom % 10 == 0) begin
          s_ad[k] = $urandom & 32'hFFFF_FFFC;
          if ($urandom % 2 == 0) s_st[k] = 32'(int'($urandom % 9) - 4) * 32'd16;
        end else begin
          s_ad[k] = s_ad[k] + s_st[k];
        end
      end
      cycle(av, s_pc[k], s_ad[k], 2, '0);
    end
    rdy_dir = 1;
    idle(4);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog run did not complete");
      finish_run();
    end
  end

endmodule